// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block is the home-node side of a directory-based coherence scheme. For every memory block it owns, it keeps a presence vector with one bit per processor and a single dirty flag. Caches send it read-miss, write-miss and write-hit-to-shared requests, each tagged with the requesting processor number. The controller works out which other caches must give up or share their copy. It sends each of them a recall or an invalidate message and collects their acknowledgements. It then rewrites the directory entry and reports completion, with the new entry and the source of the data.

One transaction engine serves all blocks. A request is taken only while the engine is free, so a request to a block with a transaction in flight waits at the request port. Messages go out one per cycle, in ascending processor order. The caches' replies arrive on an acknowledge port that carries the replying processor number. Memory data, the caches and the network are outside the block. The completion flags say whether data came from the recalled owner and whether memory was updated.

Top module: `dircoh_ctrl`

## Requirements
- R1: After reset every directory entry is empty (no presence bits, dirty clear), `req_ready` is high and neither `msg_valid` nor `done_valid` is asserted; a first read miss to any block completes with no message.
- R2: A read miss to a block whose dirty flag is clear sends no message and completes with presence = old presence OR requester bit, dirty clear, `done_src_owner` = 0, `done_mem_upd` = 0.
- R3: A read miss (`req_kind` = 0) to a dirty block owned by another processor sends one message of kind 1 (recall, owner keeps a shared copy) to the owner; it completes with presence = owner bit OR requester bit, dirty clear, `done_src_owner` = 1, `done_mem_upd` = 1.
- R4: A write miss (`req_kind` = 1) to a dirty block owned by another processor sends one message of kind 2 (recall and invalidate) to the owner; it completes with presence = requester bit only, dirty set, `done_src_owner` = 1, `done_mem_upd` = 0.
- R5: A write miss to a clean block sends a message of kind 0 (invalidate) to every processor whose presence bit is set, except the requester; it completes with presence = requester bit only, dirty set, `done_src_owner` = 0, `done_mem_upd` = 0.
- R6: A write hit (`req_kind` = 2) to a shared clean block behaves as R5: all other sharers get kind 0 and the entry becomes requester-only and dirty.
- R7: The requester is never the destination of a message, even when its own presence bit is set before the request; a request whose only holder is the requester completes with no message.
- R8: `done_valid` is not asserted until every processor messaged for the request has acknowledged; an acknowledge from a processor that was not messaged has no effect.
- R9: `req_ready` is low from the cycle after a request is accepted up to and including its `done_valid` cycle, and is high again in the following cycle; a waiting request is accepted only then.
- R10: The messages of one request go out one per cycle, in strictly ascending destination order, each target exactly once, and carry the request's block number in `msg_blk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine free; request taken when both are high |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write hit to shared |
| req_blk | input | log2(NBLK) | Block number |
| req_pid | input | log2(NPROC) | Requesting processor |
| msg_valid | output | 1 | Coherence message to a cache this cycle |
| msg_kind | output | 2 | 0 invalidate, 1 recall to shared, 2 recall and invalidate |
| msg_dest | output | log2(NPROC) | Destination processor |
| msg_blk | output | log2(NBLK) | Block the message refers to |
| ack_valid | input | 1 | Acknowledge from a cache |
| ack_pid | input | log2(NPROC) | Processor that acknowledges |
| done_valid | output | 1 | One-cycle completion pulse |
| done_pid | output | log2(NPROC) | Requester of the completed transaction |
| done_blk | output | log2(NBLK) | Block of the completed transaction |
| done_src_owner | output | 1 | Data forwarded from the recalled owner (else from memory) |
| done_mem_upd | output | 1 | Memory updated with the recalled line |
| done_pres | output | NPROC | Presence vector written to the entry |
| done_dirty | output | 1 | Dirty flag written to the entry |

## Verification
The bench aims at the owner paths: the read that downgrades a dirty owner, and the write that steals a dirty line. A design that mixed these up would send the wrong message kind, keep the owner's bit after a steal, or leave the dirty flag set after a downgrade. A write hit by a processor that is already a sharer, and a read by the dirty owner itself, check that the requester never receives a message; a design that forgot to mask it would send one message too many. A seven-sharer invalidation with slow acknowledgements and stray acknowledges from an unmessaged processor checks the ordered fan-out and the acknowledge wait; a design that counted acknowledges instead of matching them would complete too early. A request issued back to back to a busy engine checks that it is held and taken only after the earlier completion.

// File: rtl/dircoh_pkg.sv
// Package: request and message encodings shared by the controller.
package dircoh_pkg;
    typedef enum logic [1:0] {
        REQ_RD_MISS = 2'd0,
        REQ_WR_MISS = 2'd1,
        REQ_WR_HIT  = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_INV        = 2'd0,
        MSG_RECALL_SHR = 2'd1,
        MSG_RECALL_INV = 2'd2
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FAN  = 2'd1,
        ST_DONE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/dircoh_store.sv
// Directory storage: one presence vector and one dirty flag per block.
// Assumes a single reader and a single writer; reads are combinational.
module dircoh_store #(
    parameter int NPROC = 8,
    parameter int NBLK  = 16,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  logic [NPROC-1:0] wr_pres,
    input  logic             wr_dirty
);
    logic [NPROC-1:0] pres_mem  [NBLK];
    logic             dirty_mem [NBLK];

    // Clear every entry on reset, otherwise write the updated entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                pres_mem[b]  <= '0;
                dirty_mem[b] <= 1'b0;
            end
        end else if (wr_en) begin
            pres_mem[wr_blk]  <= wr_pres;
            dirty_mem[wr_blk] <= wr_dirty;
        end
    end

    // Present the addressed entry.
    always_comb begin
        rd_pres  = pres_mem[rd_blk];
        rd_dirty = dirty_mem[rd_blk];
    end
endmodule

// File: rtl/dircoh_plan.sv
// Protocol decision: from the request and the current entry, derive the
// message targets, message kind, new entry and data-source flags.
// Assumes a dirty entry has exactly one presence bit (the owner).
module dircoh_plan
    import dircoh_pkg::*;
#(
    parameter int NPROC = 8,
    localparam int PW   = $clog2(NPROC)
) (
    input  logic [1:0]       kind,
    input  logic [PW-1:0]    pid,
    input  logic [NPROC-1:0] pres,
    input  logic             dirty,
    output logic [NPROC-1:0] targets,
    output logic [1:0]       mkind,
    output logic [NPROC-1:0] new_pres,
    output logic             new_dirty,
    output logic             src_owner,
    output logic             mem_upd
);
    logic [NPROC-1:0] self_bit;
    logic [NPROC-1:0] others;
    logic             is_write;

    // Split the presence vector into requester and other holders.
    always_comb begin
        self_bit = NPROC'(1) << pid;
        others   = pres & ~self_bit;
        is_write = (kind != REQ_RD_MISS);
    end

    // Choose targets and the resulting entry for each request case.
    always_comb begin
        if (!is_write) begin
            new_pres  = pres | self_bit;
            new_dirty = 1'b0;
            targets   = dirty ? others : '0;
            mkind     = MSG_RECALL_SHR;
        end else begin
            new_pres  = self_bit;
            new_dirty = 1'b1;
            targets   = others;
            mkind     = dirty ? MSG_RECALL_INV : MSG_INV;
        end
        src_owner = dirty && (others != '0);
        mem_upd   = !is_write && dirty && (others != '0);
    end
endmodule

// File: rtl/dircoh_fanout.sv
// Message sequencer: sends one message per cycle to the lowest pending
// target and tracks which messaged caches still owe an acknowledge.
// Assumes load only while idle; acks from unmessaged caches are dropped.
module dircoh_fanout #(
    parameter int NPROC = 8,
    localparam int PW   = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic             ack_valid,
    input  logic [PW-1:0]    ack_pid,
    output logic             send_valid,
    output logic [PW-1:0]    send_dest,
    output logic             all_clear
);
    logic [NPROC-1:0] send_q;
    logic [NPROC-1:0] wait_q;
    logic [NPROC-1:0] ack_vec;
    logic [NPROC-1:0] pick_vec;

    // Find the lowest pending target.
    always_comb begin
        send_dest = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (send_q[i]) send_dest = PW'(i);
        end
        send_valid = (send_q != '0);
        pick_vec   = send_valid ? (NPROC'(1) << send_dest) : '0;
    end

    // Accept only acks from caches already messaged and still owing one.
    always_comb begin
        ack_vec   = ack_valid ? ((NPROC'(1) << ack_pid) & wait_q & ~send_q) : '0;
        all_clear = (send_q == '0) && ((wait_q & ~ack_vec) == '0);
    end

    // Advance the pending-send and pending-ack masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_q <= '0;
            wait_q <= '0;
        end else if (load) begin
            send_q <= load_mask;
            wait_q <= load_mask;
        end else begin
            send_q <= send_q & ~pick_vec;
            wait_q <= wait_q & ~ack_vec;
        end
    end
endmodule

// File: rtl/dircoh_ctrl.sv
// Top: home directory controller. One transaction engine; a request is
// taken only when idle, so a busy block's requests wait at the port.
// Assumes caches always accept a message and ack each one exactly once.
module dircoh_ctrl
    import dircoh_pkg::*;
#(
    parameter int NPROC = 8,
    parameter int NBLK  = 16,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [BW-1:0]    req_blk,
    input  logic [PW-1:0]    req_pid,
    output logic             msg_valid,
    output logic [1:0]       msg_kind,
    output logic [PW-1:0]    msg_dest,
    output logic [BW-1:0]    msg_blk,
    input  logic             ack_valid,
    input  logic [PW-1:0]    ack_pid,
    output logic             done_valid,
    output logic [PW-1:0]    done_pid,
    output logic [BW-1:0]    done_blk,
    output logic             done_src_owner,
    output logic             done_mem_upd,
    output logic [NPROC-1:0] done_pres,
    output logic             done_dirty
);
    eng_state_e       state_q;
    logic             accept;
    logic [NPROC-1:0] cur_pres;
    logic             cur_dirty;
    logic [NPROC-1:0] pl_targets;
    logic [1:0]       pl_mkind;
    logic [NPROC-1:0] pl_pres;
    logic             pl_dirty;
    logic             pl_src;
    logic             pl_upd;
    logic             fan_valid;
    logic [PW-1:0]    fan_dest;
    logic             fan_clear;
    logic [BW-1:0]    blk_q;
    logic [PW-1:0]    pid_q;
    logic [1:0]       mkind_q;
    logic [NPROC-1:0] pres_q;
    logic             dirty_q;
    logic             src_q;
    logic             upd_q;

    // Request handshake.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    dircoh_store #(.NPROC(NPROC), .NBLK(NBLK)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_blk   (req_blk),
        .rd_pres  (cur_pres),
        .rd_dirty (cur_dirty),
        .wr_en    (state_q == ST_DONE),
        .wr_blk   (blk_q),
        .wr_pres  (pres_q),
        .wr_dirty (dirty_q)
    );

    dircoh_plan #(.NPROC(NPROC)) plan_i (
        .kind      (req_kind),
        .pid       (req_pid),
        .pres      (cur_pres),
        .dirty     (cur_dirty),
        .targets   (pl_targets),
        .mkind     (pl_mkind),
        .new_pres  (pl_pres),
        .new_dirty (pl_dirty),
        .src_owner (pl_src),
        .mem_upd   (pl_upd)
    );

    dircoh_fanout #(.NPROC(NPROC)) fan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_mask  (pl_targets),
        .ack_valid  (ack_valid && (state_q == ST_FAN)),
        .ack_pid    (ack_pid),
        .send_valid (fan_valid),
        .send_dest  (fan_dest),
        .all_clear  (fan_clear)
    );

    // Engine sequencing: idle, message fan-out, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= (pl_targets == '0) ? ST_DONE : ST_FAN;
                ST_FAN:  if (fan_clear) state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request and its planned outcome at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q   <= '0;
            pid_q   <= '0;
            mkind_q <= MSG_INV;
            pres_q  <= '0;
            dirty_q <= 1'b0;
            src_q   <= 1'b0;
            upd_q   <= 1'b0;
        end else if (accept) begin
            blk_q   <= req_blk;
            pid_q   <= req_pid;
            mkind_q <= pl_mkind;
            pres_q  <= pl_pres;
            dirty_q <= pl_dirty;
            src_q   <= pl_src;
            upd_q   <= pl_upd;
        end
    end

    // Drive message and completion outputs.
    always_comb begin
        msg_valid      = fan_valid && (state_q == ST_FAN);
        msg_kind       = mkind_q;
        msg_dest       = fan_dest;
        msg_blk        = blk_q;
        done_valid     = (state_q == ST_DONE);
        done_pid       = pid_q;
        done_blk       = blk_q;
        done_src_owner = src_q;
        done_mem_upd   = upd_q;
        done_pres      = pres_q;
        done_dirty     = dirty_q;
    end
endmodule

// File: rtl/dircoh_chk.sv
// Checker: protocol properties observed at the controller's ports.
module dircoh_chk #(
    parameter int NPROC = 8,
    parameter int NBLK  = 16,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [PW-1:0]    req_pid,
    input logic             msg_valid,
    input logic [PW-1:0]    msg_dest,
    input logic             ack_valid,
    input logic [PW-1:0]    ack_pid,
    input logic             done_valid,
    input logic [PW-1:0]    done_pid,
    input logic             done_src_owner,
    input logic             done_mem_upd,
    input logic [NPROC-1:0] done_pres,
    input logic             done_dirty
);
    logic [PW-1:0]    owner_pid_q;
    logic [NPROC-1:0] owed_q;

    // Track the current requester and the caches that still owe an ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_pid_q <= '0;
            owed_q      <= '0;
        end else if (req_valid && req_ready) begin
            owner_pid_q <= req_pid;
            owed_q      <= '0;
        end else begin
            owed_q <= (owed_q & ~(ack_valid ? (NPROC'(1) << ack_pid) : '0))
                    | (msg_valid ? (NPROC'(1) << msg_dest) : '0);
        end
    end

    // R7
    no_self_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_dest != owner_pid_q));

    // R10
    msg_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && $past(msg_valid)) |-> (msg_dest > $past(msg_dest)));

    // R8
    acks_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (owed_q == '0));

    // R9
    busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !req_ready);

    // R9
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready);

    // R4
    dirty_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_dirty) |-> (($countones(done_pres) == 1) && done_pres[done_pid]));

    // R3
    memupd_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_mem_upd) |-> (!done_dirty && done_src_owner));

    // R2
    clean_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_dirty) |-> done_pres[done_pid]);
endmodule

bind dircoh_ctrl dircoh_chk #(.NPROC(NPROC), .NBLK(NBLK)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_pid        (req_pid),
    .msg_valid      (msg_valid),
    .msg_dest       (msg_dest),
    .ack_valid      (ack_valid),
    .ack_pid        (ack_pid),
    .done_valid     (done_valid),
    .done_pid       (done_pid),
    .done_src_owner (done_src_owner),
    .done_mem_upd   (done_mem_upd),
    .done_pres      (done_pres),
    .done_dirty     (done_dirty)
);

// File: tb/dircoh_ctrl_tb_top.sv
module dircoh_ctrl_tb_top;
    localparam int NPROC = 8;
    localparam int NBLK  = 16;
    localparam int PW    = 3;
    localparam int BW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_kind = '0;
    logic [BW-1:0]    req_blk = '0;
    logic [PW-1:0]    req_pid = '0;
    logic             msg_valid;
    logic [1:0]       msg_kind;
    logic [PW-1:0]    msg_dest;
    logic [BW-1:0]    msg_blk;
    logic             ack_valid = 1'b0;
    logic [PW-1:0]    ack_pid = '0;
    logic             done_valid;
    logic [PW-1:0]    done_pid;
    logic [BW-1:0]    done_blk;
    logic             done_src_owner;
    logic             done_mem_upd;
    logic [NPROC-1:0] done_pres;
    logic             done_dirty;

    always #5 clk = ~clk;

    dircoh_ctrl #(.NPROC(NPROC), .NBLK(NBLK)) dut_i (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ack_lat = 2;
    bit spur_en = 1'b0;
    logic [PW-1:0] spur_pid = '0;

    typedef struct { logic [1:0] kind; logic [PW-1:0] dest; logic [BW-1:0] blk; string tag; } msg_t;
    typedef struct { logic [PW-1:0] pid; logic [BW-1:0] blk; logic src; logic upd;
                     logic [NPROC-1:0] pres; logic dirty; string tag; } done_t;
    typedef struct { logic [PW-1:0] pid; int due; } ack_t;

    msg_t  mq[$];
    done_t dq[$];
    ack_t  aq[$];
    logic [NPROC-1:0] sh_pres [NBLK];
    logic             sh_dirty[NBLK];

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: predict the outcome from the requirements, queue it, then present the request.
    task automatic issue(logic [1:0] kind, int blk, int pid, string tag, output int stall);
        logic [NPROC-1:0] self_b, others, tgt;
        logic [1:0] mk;
        done_t d;
        self_b = NPROC'(1) << pid;
        others = sh_pres[blk] & ~self_b;
        d.pid = PW'(pid); d.blk = BW'(blk); d.tag = tag;
        d.src = sh_dirty[blk] && (others != 0);
        if (kind == 2'd0) begin
            tgt = sh_dirty[blk] ? others : '0;
            mk = 2'd1;
            d.pres = sh_pres[blk] | self_b; d.dirty = 1'b0;
            d.upd = d.src;
        end else begin
            tgt = others;
            mk = sh_dirty[blk] ? 2'd2 : 2'd0;
            d.pres = self_b; d.dirty = 1'b1; d.upd = 1'b0;
        end
        for (int i = 0; i < NPROC; i++) begin
            if (tgt[i]) mq.push_back('{kind: mk, dest: PW'(i), blk: BW'(blk), tag: tag});
        end
        dq.push_back(d);
        sh_pres[blk] = d.pres; sh_dirty[blk] = d.dirty;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_blk = BW'(blk); req_pid = PW'(pid);
        stall = 0;
        while (!req_ready) begin
            @(negedge clk);
            stall++;
        end
        @(posedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        req_valid = 1'b0;
        while (dq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor and responder: compare results as they appear, answer messages.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_valid) begin
                if (dq.size() == 0) begin
                    check(0, "R9", "unexpected completion", 1, 0);
                end else begin
                    done_t e;
                    e = dq.pop_front();
                    check(done_pid == e.pid, e.tag, "done_pid", done_pid, e.pid);
                    check(done_blk == e.blk, e.tag, "done_blk", done_blk, e.blk);
                    check(done_pres == e.pres, e.tag, "done_pres", done_pres, e.pres);
                    check(done_dirty == e.dirty, e.tag, "done_dirty", done_dirty, e.dirty);
                    check(done_src_owner == e.src, e.tag, "done_src_owner", done_src_owner, e.src);
                    check(done_mem_upd == e.upd, e.tag, "done_mem_upd", done_mem_upd, e.upd);
                    check(aq.size() == 0 && mq.size() == 0, "R8", "done before all acks", aq.size(), 0);
                end
            end
            if (msg_valid) begin
                if (mq.size() == 0) begin
                    check(0, "R7", "unexpected message dest", msg_dest, 0);
                end else begin
                    msg_t m;
                    m = mq.pop_front();
                    check(msg_dest == m.dest, m.tag, "msg_dest", msg_dest, m.dest);
                    check(msg_kind == m.kind, m.tag, "msg_kind", msg_kind, m.kind);
                    check(msg_blk == m.blk, "R10", "msg_blk", msg_blk, m.blk);
                end
                aq.push_back('{pid: msg_dest, due: cyc + ack_lat});
            end
            if (aq.size() != 0 && aq[0].due <= cyc) begin
                ack_t a;
                a = aq.pop_front();
                ack_valid = 1'b1; ack_pid = a.pid;
            end else if (spur_en) begin
                ack_valid = 1'b1; ack_pid = spur_pid;
            end else begin
                ack_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int st;
        for (int b = 0; b < NBLK; b++) begin sh_pres[b] = '0; sh_dirty[b] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
        check(done_valid == 1'b0, "R1", "done_valid after reset", done_valid, 0);

        // R1, R2: clean read misses build up sharers
        issue(2'd0, 3, 1, "R1", st); settle();
        issue(2'd0, 3, 4, "R2", st); settle();
        issue(2'd0, 3, 6, "R2", st); settle();
        // R6, R7: write hit by sharer 4 invalidates 1 and 6 only
        issue(2'd2, 3, 4, "R6", st); settle();
        // R3: read miss to dirty line recalls owner 4 to shared
        issue(2'd0, 3, 2, "R3", st); settle();
        // R5: write miss to clean line invalidates 2 and 4
        issue(2'd1, 3, 0, "R5", st); settle();
        // R4: write miss to dirty line steals from owner 0
        issue(2'd1, 3, 7, "R4", st); settle();

        // R9: back-to-back requests; the second must wait for the first
        issue(2'd0, 3, 5, "R3", st);
        issue(2'd1, 9, 5, "R9", st);
        check(st >= 1, "R9", "second request not stalled", st, 1);
        settle();
        // R7: dirty owner reads its own line: no message
        issue(2'd0, 9, 5, "R7", st); settle();

        // R10, R8: seven sharers, slow acks, stray acks from the requester
        for (int p = 1; p < NPROC; p++) begin
            issue(2'd0, 15, p, "R2", st); settle();
        end
        ack_lat = 6; spur_pid = 3'd0; spur_en = 1'b1;
        issue(2'd1, 15, 0, "R10", st); settle();
        spur_en = 1'b0; ack_lat = 2;
        // R8: block 15 now requester-only; re-read by pid 0 sends nothing
        issue(2'd0, 15, 0, "R8", st); settle();

        check(mq.size() == 0, "R10", "messages left unsent", mq.size(), 0);
        check(dq.size() == 0, "R9", "completions missing", dq.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule